// File: doc/BRIEF.md
# Address-Selected Serial Host Control Port

This block is the slave end of a three-wire synchronous serial link from a host controller, plus one open-drain return line. The host first shifts an 8-bit address in while its enable line is low. Raising enable closes the address phase, and the decoded address picks what the data phase does. In a control write, a 16-bit word is loaded into an internal control register. In a read-back, a status word captured on that enable edge is shifted out on the return line. In a checker stream, any number of bytes is assembled and handed one by one to a downstream CRC checker as a single-cycle strobe with its byte. Lowering enable ends the transfer.

All host-side lines are asynchronous to the block's system clock. They pass through a synchronizer and are edge-detected, so a host clock half period must span several system clock cycles. The return line is modelled as a pull-low request: when the request is 0 the line is released and an external pull-up gives a 1.

Top module: `ser_ctl_port`

## Requirements
- R1: Address bits are taken on rising host-clock edges while enable is low, first bit into address bit 0. On the rising edge of enable, the last eight bits taken decide the mode, provided at least eight were taken since the previous enable edge. Bits 7:4 must all be 1. Bits 3:0 equal to 4'hA (address 8'hFA) select the control write, 4'hB (8'hFB) the read-back, and 4'hC (8'hFC) the checker stream.
- R2: In a control write, data bits are taken on rising host-clock edges while enable is high, the first bit going to control bit 0. The control word output changes only on the falling edge of enable, and only if exactly 16 bits were taken.
- R3: A control write of any length other than 16 bits (for example 15 or 17) leaves the control word unchanged.
- R4: In the checker stream, each group of 8 data bits raises crc_byte_valid for exactly one system clock cycle, with the byte on crc_byte (first bit in bit 0). Consecutive bytes each give their own strobe.
- R5: Bits of an incomplete byte that remain when enable falls are dropped. They produce no strobe and do not appear in the next transfer's bytes.
- R6: In a read-back, status_word is captured on the rising edge of enable and the line stays released until the first falling host-clock edge. The k-th falling edge drives captured bit k-1 (sdo_low = inverse of the bit). Falling edges past the last bit release the line.
- R7: sdo_low is 0 whenever the port is not in a read-back: while idle, during the address phase, in control writes and in checker streams.
- R8: A transfer whose address has fewer than eight bits, or any value other than the three in R1 (for example 8'h7A or 8'hFD), is ignored. The control word is unchanged, no strobe is raised and the line stays released.
- R9: A synchronous active-high reset clears the control word, releases the line, drops any transfer in progress and lowers the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_clk | input | 1 | Host serial clock (asynchronous) |
| host_en | input | 1 | Host enable: low for the address phase, high for the data phase |
| host_di | input | 1 | Host serial data in |
| status_word | input | STAT_W | Parallel status captured for read-back |
| sdo_low | output | 1 | Request to pull the open-drain return line low; 0 releases it |
| ctrl_word | output | CTRL_W | Control register written by control transfers |
| crc_byte_valid | output | 1 | One-cycle strobe for each completed stream byte |
| crc_byte | output | BYTE_W | Byte delivered to the CRC checker |

## Verification
The hardest situations to reach from the pins are the ones where the transfer length and the enable edge interact. Examples are a control write one bit short or one bit long, an address phase with seven bits or with an extra leading bit, and a stream that stops partway through a byte and is followed by a clean byte. The stimulus builds each transfer bit by bit, with a separate enable step, so any length and any address prefix can be produced. A reset is also applied in the middle of a read-back while the line is being pulled low, to show that it is released and the control word cleared.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int ADDR_W = 8;

  // upper nibble shared by every valid address, lower nibble picks the mode
  localparam logic [3:0] SPACE_TAG = 4'hF;
  localparam logic [3:0] SEL_CTRL  = 4'hA;
  localparam logic [3:0] SEL_READ  = 4'hB;
  localparam logic [3:0] SEL_CRC   = 4'hC;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CTRL = 2'd1,
    MODE_READ = 2'd2,
    MODE_CRC  = 2'd3
  } mode_e;

  function automatic mode_e decode_addr(input logic [ADDR_W-1:0] a, input logic full);
    mode_e m;
    m = MODE_IDLE;
    if (full && (a[7:4] == SPACE_TAG)) begin
      case (a[3:0])
        SEL_CTRL: m = MODE_CTRL;
        SEL_READ: m = MODE_READ;
        SEL_CRC:  m = MODE_CRC;
        default:  m = MODE_IDLE;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/sp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous host lines.
module sp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/sp_ctrl_rx.sv
// Control-word receiver: shadow shift register, committed only on a
// closing enable edge after exactly CTRL_W bits.
module sp_ctrl_rx #(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              close,
  output logic [CTRL_W-1:0] ctrl_word
);
  localparam int CNT_W = $clog2(CTRL_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CTRL_W + 1);

  logic [CTRL_W-1:0] shadow_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      cnt_q    <= '0;
    end else if (!active || close) begin
      cnt_q <= '0;
    end else if (bit_stb) begin
      shadow_q <= {bit_val, shadow_q[CTRL_W-1:1]};
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     ctrl_q <= '0;
    else if (active && close && cnt_q == CNT_FULL) ctrl_q <= shadow_q;
  end

  assign ctrl_word = ctrl_q;

  // R3
  bad_length_chk: assert property (@(posedge clk) disable iff (rst)
    (close && cnt_q != CNT_FULL) |=> $stable(ctrl_q));

endmodule

// File: rtl/sp_byte_rx.sv
// Byte assembler for the checker stream: one strobe per completed byte.
module sp_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!active) begin
        cnt_q <= '0;
      end else if (bit_stb) begin
        sh_q <= {bit_val, sh_q[BYTE_W-1:1]};
        if (cnt_q == CNT_LAST) begin
          cnt_q   <= '0;
          data_q  <= {bit_val, sh_q[BYTE_W-1:1]};
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_valid = valid_q;
  assign byte_data  = data_q;

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

endmodule

// File: rtl/sp_stat_tx.sv
// Read-back shifter: captured word leaves LSB first, one bit per falling
// host-clock edge, ones fill behind it so the line ends up released.
module sp_stat_tx #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              clear,
  input  logic              shift,
  output logic              sdo_low
);
  logic [STAT_W-1:0] sh_q;
  logic              low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '1;
      low_q <= 1'b0;
    end else if (load) begin
      sh_q  <= stat_in;
      low_q <= 1'b0;
    end else if (clear) begin
      sh_q  <= '1;
      low_q <= 1'b0;
    end else if (shift) begin
      low_q <= ~sh_q[0];
      sh_q  <= {1'b1, sh_q[STAT_W-1:1]};
    end
  end

  assign sdo_low = low_q;

  // R6
  released_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !low_q);

endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import sp_pkg::*;
#(
  parameter int CTRL_W      = 16,
  parameter int STAT_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_clk,
  input  logic              host_en,
  input  logic              host_di,
  input  logic [STAT_W-1:0] status_word,
  output logic              sdo_low,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              crc_byte_valid,
  output logic [BYTE_W-1:0] crc_byte
);
  localparam int ACNT_W = $clog2(ADDR_W + 1);
  localparam logic [ACNT_W-1:0] ACNT_FULL = ACNT_W'(ADDR_W);

  // synchronized host lines: bit0 clock, bit1 enable, bit2 data
  logic [2:0] lvl;
  logic       hc_q, en_q;
  logic       hc_rise, hc_fall, en_rise, en_fall, di_lvl, en_lvl;

  sp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({host_di, host_en, host_clk}),
    .dout (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      hc_q <= lvl[0];
      en_q <= lvl[1];
    end
  end

  assign hc_rise = lvl[0] & ~hc_q;
  assign hc_fall = ~lvl[0] & hc_q;
  assign en_rise = lvl[1] & ~en_q;
  assign en_fall = ~lvl[1] & en_q;
  assign en_lvl  = lvl[1];
  assign di_lvl  = lvl[2];

  // address phase and mode selection
  logic [ADDR_W-1:0] addr_q;
  logic [ACNT_W-1:0] acnt_q;
  mode_e             mode_q;
  mode_e             sel_mode;
  logic              addr_take;

  assign sel_mode  = decode_addr(addr_q, acnt_q == ACNT_FULL);
  assign addr_take = hc_rise && !en_lvl && (mode_q == MODE_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      acnt_q <= '0;
      mode_q <= MODE_IDLE;
    end else if (en_rise) begin
      mode_q <= sel_mode;
      acnt_q <= '0;
    end else if (en_fall) begin
      mode_q <= MODE_IDLE;
      acnt_q <= '0;
    end else if (addr_take) begin
      addr_q <= {di_lvl, addr_q[ADDR_W-1:1]};
      if (acnt_q != ACNT_FULL) acnt_q <= acnt_q + 1'b1;
    end
  end

  // data-phase engines
  sp_ctrl_rx #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .active    (mode_q == MODE_CTRL),
    .bit_stb   (hc_rise),
    .bit_val   (di_lvl),
    .close     (en_fall),
    .ctrl_word (ctrl_word)
  );

  sp_byte_rx #(.BYTE_W(BYTE_W)) u_bytes (
    .clk        (clk),
    .rst        (rst),
    .active     (mode_q == MODE_CRC),
    .bit_stb    (hc_rise),
    .bit_val    (di_lvl),
    .byte_valid (crc_byte_valid),
    .byte_data  (crc_byte)
  );

  sp_stat_tx #(.STAT_W(STAT_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .load    (en_rise && (sel_mode == MODE_READ)),
    .stat_in (status_word),
    .clear   ((mode_q != MODE_READ) || en_fall),
    .shift   (hc_fall && (mode_q == MODE_READ)),
    .sdo_low (sdo_low)
  );

  // R1
  mode_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_IDLE && $past(mode_q) == MODE_IDLE) |-> $past(en_rise));

  // R7
  line_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_READ) |-> !sdo_low);

  // R2
  ctrl_on_close_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_word) |-> $past(en_fall));

  // R4
  strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    crc_byte_valid |-> $past(mode_q == MODE_CRC));

endmodule

// File: tb/test_ser_ctl_port.sv
module test_ser_ctl_port;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_clk = 1'b0;
  logic host_en = 1'b0;
  logic host_di = 1'b0;
  logic [15:0] status_word = '0;
  logic        sdo_low;
  logic [15:0] ctrl_word;
  logic        crc_byte_valid;
  logic [7:0]  crc_byte;

  int checks = 0;
  int errors = 0;
  int settle = 8;
  int n_strobe = 0;
  int n_exp_strobe = 0;
  bit done = 1'b0;
  string cur_tag = "R9";

  // behavioural model state
  logic [15:0] exp_ctrl = '0;
  logic        exp_low = 1'b0;
  logic [7:0]  exp_bytes[$];
  int          m_mode = 0;      // 0 idle, 1 control, 2 read-back, 3 stream
  logic [7:0]  m_addr = '0;
  int          m_acnt = 0;
  logic        m_bits[$];
  logic [15:0] m_stat = '0;
  int          m_rd_idx = 0;

  always #4 clk = ~clk;

  ser_ctl_port i_ser_ctl_port (
    .clk            (clk),
    .rst            (rst),
    .host_clk       (host_clk),
    .host_en        (host_en),
    .host_di        (host_di),
    .status_word    (status_word),
    .sdo_low        (sdo_low),
    .ctrl_word      (ctrl_word),
    .crc_byte_valid (crc_byte_valid),
    .crc_byte       (crc_byte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, sampled away from the edge
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      if (crc_byte_valid) begin
        n_strobe++;
        if (exp_bytes.size() == 0) chk("R4/R8 unexpected byte strobe", 1, 0);
        else chk("R4 streamed byte", crc_byte, exp_bytes.pop_front());
      end
      if (settle > 0) settle--;
      else begin
        chk({cur_tag, " control word"}, ctrl_word, exp_ctrl);
        chk({cur_tag, " data line"}, sdo_low, exp_low);
      end
    end
  end

  task automatic model_rise(input logic d);
    logic [7:0] b;
    if (!host_en) begin
      m_addr = {d, m_addr[7:1]};
      if (m_acnt < 8) m_acnt++;
    end else if (m_mode == 1 || m_mode == 3) begin
      m_bits.push_back(d);
      if (m_mode == 3 && m_bits.size() == 8) begin
        for (int i = 0; i < 8; i++) b[i] = m_bits[i];
        exp_bytes.push_back(b);
        n_exp_strobe++;
        m_bits.delete();
      end
    end
  endtask

  task automatic model_fall();
    if (m_mode == 2) begin
      exp_low = (m_rd_idx < 16) ? ~m_stat[m_rd_idx] : 1'b0;
      m_rd_idx++;
    end
  endtask

  task automatic hbit(input logic d);
    @(negedge clk);
    host_di = d; settle = 4;
    repeat (HALF) @(negedge clk);
    host_clk = 1'b1; settle = 4; model_rise(d);
    repeat (HALF) @(negedge clk);
    host_clk = 1'b0; settle = 4; model_fall();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic en_up();
    @(negedge clk);
    host_en = 1'b1; settle = 4;
    m_mode = 0;
    if (m_acnt >= 8 && m_addr[7:4] == 4'hF) begin
      case (m_addr[3:0])
        4'hA: m_mode = 1;
        4'hB: m_mode = 2;
        4'hC: m_mode = 3;
        default: m_mode = 0;
      endcase
    end
    m_acnt = 0; m_bits.delete(); m_stat = status_word; m_rd_idx = 0; exp_low = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic en_down();
    @(negedge clk);
    host_en = 1'b0; settle = 4;
    if (m_mode == 1 && m_bits.size() == 16)
      for (int i = 0; i < 16; i++) exp_ctrl[i] = m_bits[i];
    m_mode = 0; m_acnt = 0; m_bits.delete(); exp_low = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] a, input logic [31:0] data, input int nd);
    for (int i = 0; i < 8; i++) hbit(a[i]);
    en_up();
    for (int i = 0; i < nd; i++) hbit(data[i]);
    en_down();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_en = 1'b0; host_clk = 1'b0; host_di = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; settle = 4;
    exp_ctrl = '0; exp_low = 1'b0; exp_bytes.delete();
    m_mode = 0; m_acnt = 0; m_bits.delete();
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0; settle = 4;
    repeat (6) @(negedge clk);
    // R9 reset state
    chk("R9 reset control word", ctrl_word, 16'h0000);
    chk("R9 reset data line", sdo_low, 0);
    chk("R9 reset strobe", crc_byte_valid, 0);

    // R2 exact-length control write
    cur_tag = "R2";
    xfer(8'hFA, 32'h0000_A5C3, 16);
    chk("R2 control word after 16 bits", ctrl_word, 16'hA5C3);

    // R3 short and long control writes
    cur_tag = "R3";
    xfer(8'hFA, 32'h0000_1234, 15);
    chk("R3 15-bit write discarded", ctrl_word, 16'hA5C3);
    xfer(8'hFA, 32'h0001_1234, 17);
    chk("R3 17-bit write discarded", ctrl_word, 16'hA5C3);

    // R1 nine address bits: the last eight select the mode
    cur_tag = "R1";
    hbit(1'b1);
    xfer(8'hFA, 32'h0000_0F0F, 16);
    chk("R1 last eight address bits used", ctrl_word, 16'h0F0F);

    // R8 seven-bit address is ignored
    cur_tag = "R8";
    for (int i = 1; i < 8; i++) hbit(1'(8'hFA >> i));
    en_up();
    for (int i = 0; i < 16; i++) hbit(1'(16'h5555 >> i));
    en_down();
    chk("R8 short address ignored", ctrl_word, 16'h0F0F);
    // R8 wrong upper nibble and unused selector
    xfer(8'h7A, 32'h0000_FFFF, 16);
    chk("R8 address 7A ignored", ctrl_word, 16'h0F0F);
    xfer(8'hFD, 32'h00FF_FFFF, 24);
    chk("R8 address FD no strobes", n_strobe, 0);
    chk("R8 address FD line released", sdo_low, 0);

    // R4 three-byte stream; R7 line released meanwhile
    cur_tag = "R7";
    xfer(8'hFC, 32'h00FF_813C, 24);
    chk("R4 three strobes", n_strobe, 3);
    chk("R7 line released after stream", sdo_low, 0);

    // R5 partial byte dropped, next byte clean
    cur_tag = "R5";
    xfer(8'hFC, 32'h0000_0A5E, 12);
    chk("R5 one strobe for 12 bits", n_strobe, 4);
    xfer(8'hFC, 32'h0000_0069, 8);
    chk("R5 following byte count", n_strobe, 5);

    // R6 read-back with capture on enable rise
    cur_tag = "R6";
    status_word = 16'h8D32;
    for (int i = 0; i < 8; i++) hbit(1'(8'hFB >> i));
    en_up();
    status_word = 16'h0000;
    chk("R6 released before first falling edge", sdo_low, 0);
    hbit(1'b0);
    chk("R6 bit0 (0) pulls low", sdo_low, 1);
    hbit(1'b0);
    chk("R6 bit1 (1) releases", sdo_low, 0);
    for (int i = 2; i < 18; i++) hbit(1'b0);
    chk("R6 released past last bit", sdo_low, 0);
    en_down();

    // R9 reset during a read-back that pulls the line low
    cur_tag = "R9";
    status_word = 16'h0000;
    for (int i = 0; i < 8; i++) hbit(1'(8'hFB >> i));
    en_up();
    hbit(1'b0);
    chk("R6 zero bit pulls low", sdo_low, 1);
    do_reset();
    chk("R9 line released by reset", sdo_low, 0);
    chk("R9 control word cleared by reset", ctrl_word, 16'h0000);

    repeat (10) @(negedge clk);
    chk("R4 all expected bytes seen", exp_bytes.size(), 0);
    chk("R4 strobe total", n_strobe, n_exp_strobe);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule